// File: doc/BRIEF.md
# VGA Cell Grid Renderer

This block draws a grid of cells on a VGA monitor. It runs a horizontal and a vertical pixel counter over a fixed raster. It decodes the two sync pulses directly from the counter values. It also paints each screen pixel that falls inside a live cell. The raster is 768 columns by 512 lines. Horizontal sync spans the first sixteen columns of every line, and vertical sync spans the whole of line 0.

Each cell is a square of 20 by 20 pixels. The squares are laid out as a regular array whose top-left corner sits at pixel (200, 200). The caller supplies one state bit per cell on a flat input vector. The bit for the cell in row `r` and column `c` is `cells_i[r*GRID_COLS + c]`. A compile-time mask selects which of the red, green and blue outputs show live cells. The default mask lights red only.

Every output is registered. The values seen after a clock edge therefore describe the pixel that the counters held before that edge.

Top module: `cell_grid_vga`

## Requirements
- R1: The horizontal position steps by one per clock from 0 to H_TOTAL-1 (default 767) and then returns to 0. Seen at the ports, successive rising edges of `hsync_o` are exactly H_TOTAL clocks apart.
- R2: The line number changes only at the end of a line, after column H_TOTAL-1. As a result, `vsync_o` stays high for exactly H_TOTAL consecutive clocks.
- R3: After the last column of line V_TOTAL-1 (default 511), the line number returns to 0. Successive rising edges of `vsync_o` are therefore exactly H_TOTAL*V_TOTAL clocks apart.
- R4: `hsync_o` is high exactly when all counter bits at or above bit HS_LOW_BITS (default 4) are zero. With the default, this means column x < 16.
- R5: `vsync_o` is high exactly when the line number is 0.
- R6: For a pixel with CELL_ORG_X + CELL_PX*c <= x < CELL_ORG_X + CELL_PX*(c+1) and CELL_ORG_Y + CELL_PX*r <= y < CELL_ORG_Y + CELL_PX*(r+1), where c < GRID_COLS and r < GRID_ROWS, each colour output enabled in PAINT_RGB equals `cells_i[r*GRID_COLS + c]`. PAINT_RGB bit 2 enables red, bit 1 green and bit 0 blue. A disabled colour stays low.
- R7: For a pixel outside the whole grid rectangle, all three colour outputs are low, whatever `cells_i` holds.
- R8: While `hsync_o` or `vsync_o` is high, all three colour outputs are low.
- R9: A synchronous active-high reset drives every output low and puts the position at (0, 0). Each output is registered, so on the first clock edge after reset is released the outputs show pixel (0, 0). After edge k they show the pixel at position k-1 of the raster scan.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cells_i | input | GRID_COLS*GRID_ROWS | Cell state bits, row-major, 1 = live |
| hsync_o | output | 1 | Horizontal sync, registered, active high |
| vsync_o | output | 1 | Vertical sync, registered, active high |
| red_o | output | 1 | Red colour bit, registered |
| green_o | output | 1 | Green colour bit, registered |
| blue_o | output | 1 | Blue colour bit, registered |

## Verification
On every cycle, the assertions check how the two counters step and wrap, and how each sync output follows the counter value of the cycle before. They also check that colour is blanked during sync and to the left or right of the grid. The cell-to-bit mapping can only be shown by the bench's scenarios. So can the period of sync pulses measured at the ports, and the recovery of the scan phase after a reset partway through a frame. The bench sweeps every pixel of several full frames of a reduced raster, using uniform, checkerboard and walking-one cell patterns. It also changes the pattern partway through a frame.

// File: rtl/cgv_pkg.sv
package cgv_pkg;

  // Registered pixel-side outputs, kept together so they share one register stage.
  typedef struct packed {
    logic hs;
    logic vs;
    logic red;
    logic grn;
    logic blu;
  } px_out_t;

  // Number of bits needed to hold values 0..n-1; at least one bit.
  function automatic int unsigned width_of(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/cgv_raster.sv
module cgv_raster #(
  parameter int unsigned H_TOTAL = 768,
  parameter int unsigned V_TOTAL = 512,
  parameter int unsigned HW      = 10,
  parameter int unsigned VW      = 9
) (
  input  logic          clk_i,
  input  logic          rst_i,
  output logic [HW-1:0] hcnt_o,
  output logic [VW-1:0] vcnt_o
);

  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);

  logic line_end;
  assign line_end = (hcnt_o == H_LAST);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      hcnt_o <= '0;
    end else if (line_end) begin
      hcnt_o <= '0;
    end else begin
      hcnt_o <= hcnt_o + HW'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      vcnt_o <= '0;
    end else if (line_end) begin
      if (vcnt_o == V_LAST) begin
        vcnt_o <= '0;
      end else begin
        vcnt_o <= vcnt_o + VW'(1);
      end
    end
  end

endmodule

// File: rtl/cgv_axis_map.sv
module cgv_axis_map #(
  parameter int unsigned PW    = 10,
  parameter int unsigned ORG   = 200,
  parameter int unsigned CELL  = 20,
  parameter int unsigned COUNT = 4,
  parameter int unsigned IW    = 2
) (
  input  logic [PW-1:0] pos_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o
);

  localparam int unsigned SPAN_END = ORG + CELL * COUNT;

  always_comb begin
    int unsigned p;
    p     = 32'(pos_i);
    hit_o = (p >= ORG) && (p < SPAN_END);
    if (hit_o) begin
      idx_o = IW'((p - ORG) / CELL);
    end else begin
      idx_o = '0;
    end
  end

endmodule

// File: rtl/cgv_pixel_out.sv
module cgv_pixel_out #(
  parameter logic [2:0] PAINT_RGB = 3'b100
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              hs_raw_i,
  input  logic              vs_raw_i,
  input  logic              inside_i,
  input  logic              live_i,
  output cgv_pkg::px_out_t  px_o
);

  logic       lit;
  logic [2:0] rgb_nxt;

  assign lit = inside_i & live_i & ~hs_raw_i & ~vs_raw_i;

  for (genvar ch = 0; ch < 3; ch++) begin : g_chan
    if (PAINT_RGB[ch]) begin : g_on
      assign rgb_nxt[ch] = lit;
    end else begin : g_off
      assign rgb_nxt[ch] = 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      px_o <= '0;
    end else begin
      px_o.hs  <= hs_raw_i;
      px_o.vs  <= vs_raw_i;
      px_o.red <= rgb_nxt[2];
      px_o.grn <= rgb_nxt[1];
      px_o.blu <= rgb_nxt[0];
    end
  end

endmodule

// File: rtl/cell_grid_vga.sv
module cell_grid_vga #(
  parameter int unsigned H_TOTAL     = 768,
  parameter int unsigned V_TOTAL     = 512,
  parameter int unsigned HS_LOW_BITS = 4,
  parameter int unsigned CELL_PX     = 20,
  parameter int unsigned CELL_ORG_X  = 200,
  parameter int unsigned CELL_ORG_Y  = 200,
  parameter int unsigned GRID_COLS   = 4,
  parameter int unsigned GRID_ROWS   = 4,
  parameter logic [2:0]  PAINT_RGB   = 3'b100
) (
  input  logic                           clk_i,
  input  logic                           rst_i,
  input  logic [GRID_COLS*GRID_ROWS-1:0] cells_i,
  output logic                           hsync_o,
  output logic                           vsync_o,
  output logic                           red_o,
  output logic                           green_o,
  output logic                           blue_o
);

  localparam int unsigned NCELL = GRID_COLS * GRID_ROWS;
  localparam int unsigned HW    = cgv_pkg::width_of(H_TOTAL);
  localparam int unsigned VW    = cgv_pkg::width_of(V_TOTAL);
  localparam int unsigned CW    = cgv_pkg::width_of(GRID_COLS);
  localparam int unsigned RW    = cgv_pkg::width_of(GRID_ROWS);
  localparam int unsigned SW    = cgv_pkg::width_of(NCELL);

  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic          hs_raw, vs_raw;
  logic          hit_x, hit_y;
  logic [CW-1:0] col;
  logic [RW-1:0] row;
  logic [SW-1:0] cell_sel;
  logic          live;
  cgv_pkg::px_out_t px;

  cgv_raster #(
    .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .HW(HW), .VW(VW)
  ) u_raster (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .hcnt_o(hcnt),
    .vcnt_o(vcnt)
  );

  // Sync decode straight from the counter values.
  assign hs_raw = ((hcnt >> HS_LOW_BITS) == '0);
  assign vs_raw = (vcnt == '0);

  cgv_axis_map #(
    .PW(HW), .ORG(CELL_ORG_X), .CELL(CELL_PX), .COUNT(GRID_COLS), .IW(CW)
  ) u_map_x (
    .pos_i(hcnt),
    .hit_o(hit_x),
    .idx_o(col)
  );

  cgv_axis_map #(
    .PW(VW), .ORG(CELL_ORG_Y), .CELL(CELL_PX), .COUNT(GRID_ROWS), .IW(RW)
  ) u_map_y (
    .pos_i(vcnt),
    .hit_o(hit_y),
    .idx_o(row)
  );

  // Row-major cell selection.
  assign cell_sel = SW'(32'(row) * GRID_COLS + 32'(col));
  assign live     = cells_i[cell_sel];

  cgv_pixel_out #(
    .PAINT_RGB(PAINT_RGB)
  ) u_pix (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .hs_raw_i(hs_raw),
    .vs_raw_i(vs_raw),
    .inside_i(hit_x & hit_y),
    .live_i  (live),
    .px_o    (px)
  );

  assign hsync_o = px.hs;
  assign vsync_o = px.vs;
  assign red_o   = px.red;
  assign green_o = px.grn;
  assign blue_o  = px.blu;

endmodule

// File: rtl/cell_grid_vga_chk.sv
module cell_grid_vga_chk #(
  parameter int unsigned H_TOTAL     = 768,
  parameter int unsigned V_TOTAL     = 512,
  parameter int unsigned HS_LOW_BITS = 4,
  parameter int unsigned X_LO        = 200,
  parameter int unsigned X_HI        = 280,
  parameter int unsigned HW          = 10,
  parameter int unsigned VW          = 9
) (
  input logic          clk,
  input logic          rst,
  input logic [HW-1:0] hcnt,
  input logic [VW-1:0] vcnt,
  input logic          hs,
  input logic          vs,
  input logic          r,
  input logic          g,
  input logic          b
);

  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);

  a_r1_hwrap: assert property (@(posedge clk) disable iff (rst)
    (hcnt == H_LAST) |=> (hcnt == '0));

  a_r1_hstep: assert property (@(posedge clk) disable iff (rst)
    (hcnt != H_LAST) |=> (32'(hcnt) == 32'($past(hcnt)) + 1));

  a_r2_vhold: assert property (@(posedge clk) disable iff (rst)
    (hcnt != H_LAST) |=> $stable(vcnt));

  a_r2_vstep: assert property (@(posedge clk) disable iff (rst)
    (hcnt == H_LAST && vcnt != V_LAST) |=> (32'(vcnt) == 32'($past(vcnt)) + 1));

  a_r3_vwrap: assert property (@(posedge clk) disable iff (rst)
    (hcnt == H_LAST && vcnt == V_LAST) |=> (vcnt == '0));

  a_r4_hsync: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (hs == ((32'($past(hcnt)) >> HS_LOW_BITS) == 0)));

  a_r5_vsync: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (vs == ($past(vcnt) == '0)));

  a_r7_side_dark: assert property (@(posedge clk) disable iff (rst)
    (32'(hcnt) < X_LO || 32'(hcnt) >= X_HI) |=> !(r || g || b));

  a_r8_sync_dark: assert property (@(posedge clk) disable iff (rst)
    (hs || vs) |-> !(r || g || b));

endmodule

bind cell_grid_vga cell_grid_vga_chk #(
  .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .HS_LOW_BITS(HS_LOW_BITS),
  .X_LO(CELL_ORG_X), .X_HI(CELL_ORG_X + CELL_PX * GRID_COLS),
  .HW(HW), .VW(VW)
) u_chk (
  .clk (clk_i),
  .rst (rst_i),
  .hcnt(hcnt),
  .vcnt(vcnt),
  .hs  (hsync_o),
  .vs  (vsync_o),
  .r   (red_o),
  .g   (green_o),
  .b   (blue_o)
);

// File: tb/tb_cell_grid_vga.sv
module tb_cell_grid_vga;

  localparam int H    = 64;
  localparam int V    = 40;
  localparam int HSB  = 4;
  localparam int CPX  = 4;
  localparam int OX   = 20;
  localparam int OY   = 8;
  localparam int COLS = 4;
  localparam int ROWS = 3;
  localparam int N    = COLS * ROWS;
  localparam logic [2:0] MASK = 3'b101;
  localparam int FRAME = H * V;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] cells = '0;
  logic hs, vs, r, g, b;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  int k;                 // pixel index the next check compares against
  int hs_last, vs_last, vs_rise_at;
  logic hs_prev, vs_prev;

  always #5 clk = ~clk;

  cell_grid_vga #(
    .H_TOTAL(H), .V_TOTAL(V), .HS_LOW_BITS(HSB), .CELL_PX(CPX),
    .CELL_ORG_X(OX), .CELL_ORG_Y(OY), .GRID_COLS(COLS), .GRID_ROWS(ROWS),
    .PAINT_RGB(MASK)
  ) dut (
    .clk_i(clk), .rst_i(rst), .cells_i(cells),
    .hsync_o(hs), .vsync_o(vs), .red_o(r), .green_o(g), .blue_o(b)
  );

  function automatic logic [4:0] model(input int p, input logic [N-1:0] c);
    int x, y;
    logic hsx, vsx, bit_v;
    x = p % H;
    y = (p / H) % V;
    hsx = ((x >> HSB) == 0);
    vsx = (y == 0);
    bit_v = 1'b0;
    if (x >= OX && x < OX + CPX*COLS && y >= OY && y < OY + CPX*ROWS)
      bit_v = c[((y - OY) / CPX) * COLS + (x - OX) / CPX];
    if (hsx || vsx) bit_v = 1'b0;
    return {hsx, vsx, bit_v ? MASK : 3'b000};
  endfunction

  function automatic string tag_of(input int p);
    int x, y;
    x = p % H;
    y = (p / H) % V;
    if ((x >> HSB) == 0 || y == 0) return "R8";
    if (x >= OX && x < OX + CPX*COLS && y >= OY && y < OY + CPX*ROWS) return "R6";
    return "R7";
  endfunction

  task automatic cmp(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at pixel %0d: actual=%0h expected=%0h", tag, k, act, exp);
    end
  endtask

  // One clock: sample at the falling edge the pixel the last rising edge produced.
  task automatic step();
    logic [4:0] act, exp;
    @(negedge clk);
    act = {hs, vs, r, g, b};
    exp = model(k, cells);
    if (act[4:3] != exp[4:3]) begin
      cmp(act[4] != exp[4] ? "R4" : "R5", int'(act[4:3]), int'(exp[4:3]));
    end else begin
      cmp(tag_of(k), int'(act), int'(exp));
    end
    if (hs && !hs_prev) begin
      if (hs_last >= 0) cmp("R1", k - hs_last, H);
      hs_last = k;
    end
    if (vs && !vs_prev) begin
      if (vs_last >= 0) cmp("R3", k - vs_last, FRAME);
      vs_last = k;
      vs_rise_at = k;
    end
    if (!vs && vs_prev) cmp("R2", k - vs_rise_at, H);
    hs_prev = hs;
    vs_prev = vs;
    k++;
  endtask

  task automatic restart_tracking();
    k = 0;
    hs_last = -1;
    vs_last = -1;
    vs_rise_at = 0;
    hs_prev = 1'b0;
    vs_prev = 1'b0;
  endtask

  task automatic run_cycles(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic check_reset_state();
    @(negedge clk);
    cmp("R9", int'({hs, vs, r, g, b}), 0);
  endtask

  initial begin
    restart_tracking();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check_reset_state();           // R9: outputs low in reset
    rst = 1'b0;                    // next rising edge shows pixel (0,0)

    cells = '0;                    run_cycles(FRAME);       // R6/R7 with all dead
    cells = '1;                    run_cycles(2 * FRAME);   // all live, wrap of R3
    cells = 12'hA5A;               run_cycles(FRAME);       // checkerboard-like
    for (int c = 0; c < N; c++) begin                      // walking one over every cell
      cells = N'(1) << c;
      run_cycles(FRAME);
    end
    cells = 12'h3C6;               run_cycles(FRAME / 2 + 7);
    cells = 12'hC39;               run_cycles(FRAME / 2 + 9);  // change partway through a frame

    // Reset partway through a frame: outputs clear and scan restarts at (0,0) (R9).
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check_reset_state();
    restart_tracking();
    rst = 1'b0;
    cells = '1;                    run_cycles(FRAME + H);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL R9 watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule